// File: doc/BRIEF.md
# Ternary Logic Primitive Unit

This unit evaluates the basic radix-3 gates on a row of independent ternary digits. Each digit travels on two wires: 2'b00 means 0, 2'b01 means 1, 2'b10 means 2, and 2'b11 is a code no legal digit uses. One operation select applies to every lane of a transfer. The unit returns one of five functions per lane:

- the complement of operand A, which is two minus the value;
- the minimum of A and B, the ternary AND;
- the sum of A and B clipped at 2, the ternary OR;
- the complement of the minimum, the ternary NAND;
- the complement of the clipped sum, the ternary NOR.

A per-lane flag reports a lane whose result is not meaningful.

Operands enter on a valid/ready input channel and results leave on a valid/ready output channel, with one register stage between them. An input transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that cycle. A result stays on the output, unchanged, until the consumer raises `out_ready`. The upstream side may hold `in_valid` for as long as it needs.

Top module: `tern_prim_unit`

## Requirements
- R1: With select 0, each lane returns the complement of its A digit (0 gives 2, 1 gives 1, 2 gives 0), using the encoding 00=0, 01=1, 10=2. A legal lane never returns 2'b11.
- R2: With select 1, each lane returns the smaller of its A and B digits.
- R3: With select 2, each lane returns A+B clipped at 2 (for example, 1 and 1 give 2, and 0 and 1 give 1).
- R4: With select 3, each lane returns 2 minus the minimum of A and B.
- R5: With select 4, each lane returns 2 minus the clipped sum of A and B.
- R6: A lane whose A or B digit is 2'b11 has its bit in `lane_bad` set and its result forced to 2'b00. The other lanes of the same transfer are computed normally and keep their flags clear.
- R7: Select values 5, 6 and 7 set every bit of `lane_bad` and return 2'b00 in every lane.
- R8: A result appears on the output with `out_valid` on the clock edge after its input transfer. While `out_valid` is high and `out_ready` is low, the result and flags hold steady and `in_ready` is low. Results leave in the order their inputs were accepted, with none lost and none repeated.
- R9: While reset is asserted, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and select are offered |
| in_ready | output | 1 | Unit can take a transfer this cycle |
| op_sel | input | 3 | Operation: 0 complement A, 1 min, 2 tsum, 3 NAND, 4 NOR |
| opa | input | 2*LANES | Operand A digits, lane i on bits 2i+1:2i |
| opb | input | 2*LANES | Operand B digits, same lane layout |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 2*LANES | Result digits, same lane layout |
| lane_bad | output | LANES | Per-lane flag for an illegal operand code or an illegal select |

## Verification
Every legal operand pair is driven through every lane for all five operations. The pairs are rotated across lanes, so a swapped lane, a mis-ordered encoding or an off-by-one clip at 2 shows up as a wrong digit in a named lane. Illegal 2'b11 digits are placed in single lanes next to legal ones. A design that flagged the whole word, or that forgot to clear the bad lane to zero, would mismatch the scoreboard. The unused selects are sent as well, and a design that decoded them as a real operation would return nonzero digits. The operation sweep is repeated under an irregular `out_ready` pattern. A design that dropped, duplicated or changed a stalled result would break the queue order or the hold comparison.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t T_ZERO = 2'b00;
  localparam trit_t T_ONE  = 2'b01;
  localparam trit_t T_TWO  = 2'b10;
  localparam trit_t T_BAD  = 2'b11;

  typedef enum logic [2:0] {
    OP_INV  = 3'd0,
    OP_MIN  = 3'd1,
    OP_TSUM = 3'd2,
    OP_NAND = 3'd3,
    OP_NOR  = 3'd4
  } tern_op_e;

  localparam logic [2:0] OP_LAST = 3'd4;

  // radix-3 complement: (r-1) - v
  function automatic trit_t trit_inv(trit_t v);
    case (v)
      T_ZERO:  trit_inv = T_TWO;
      T_ONE:   trit_inv = T_ONE;
      default: trit_inv = T_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/tern_lane.sv
module tern_lane
  import tern_pkg::*;
(
  input  logic [2:0] op_sel,
  input  trit_t      a,
  input  trit_t      b,
  output trit_t      res,
  output logic       bad
);
  logic  code_bad;
  logic  op_ok;
  trit_t smaller;
  logic [2:0] raw_sum;
  trit_t clipped;
  trit_t pick;

  always_comb begin
    code_bad = (a == T_BAD) || (b == T_BAD);
    op_ok    = (op_sel <= OP_LAST);
    // legal codes order the same way as their values
    smaller  = (a < b) ? a : b;
    raw_sum  = {1'b0, a} + {1'b0, b};
    clipped  = (raw_sum >= 3'd2) ? T_TWO : raw_sum[1:0];
    case (op_sel)
      OP_INV:  pick = trit_inv(a);
      OP_MIN:  pick = smaller;
      OP_TSUM: pick = clipped;
      OP_NAND: pick = trit_inv(smaller);
      OP_NOR:  pick = trit_inv(clipped);
      default: pick = T_ZERO;
    endcase
    bad = code_bad || !op_ok;
    res = bad ? T_ZERO : pick;
  end
endmodule

// File: rtl/tern_out_stage.sv
module tern_out_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) q <= d;
    end
  end
endmodule

// File: rtl/tern_prim_unit.sv
module tern_prim_unit
  import tern_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2:0]         op_sel,
  input  logic [2*LANES-1:0] opa,
  input  logic [2*LANES-1:0] opb,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [2*LANES-1:0] result,
  output logic [LANES-1:0]   lane_bad
);
  localparam int RW = 2 * LANES;
  localparam int SW = RW + LANES;

  logic [RW-1:0]    comb_res;
  logic [LANES-1:0] comb_bad;
  logic [SW-1:0]    stage_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    tern_lane u_lane (
      .op_sel (op_sel),
      .a      (opa[2*i +: 2]),
      .b      (opb[2*i +: 2]),
      .res    (comb_res[2*i +: 2]),
      .bad    (comb_bad[i])
    );
  end

  tern_out_stage #(.W(SW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         ({comb_bad, comb_res}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (stage_q)
  );

  assign result   = stage_q[RW-1:0];
  assign lane_bad = stage_q[SW-1:RW];
endmodule

// File: rtl/tern_prim_chk.sv
module tern_prim_chk #(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [2:0]         op_sel,
  input logic [2*LANES-1:0] opa,
  input logic [2*LANES-1:0] opb,
  input logic               out_valid,
  input logic               out_ready,
  input logic [2*LANES-1:0] result,
  input logic [LANES-1:0]   lane_bad
);
  // R8
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(lane_bad)));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  bad_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (op_sel > 3'd4)) |=> (&lane_bad));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !lane_bad[i]) |-> (result[2*i +: 2] != 2'b11));

    // R6
    bad_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && lane_bad[i]) |-> (result[2*i +: 2] == 2'b00));

    // R6
    bad_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && ((opa[2*i +: 2] == 2'b11) || (opb[2*i +: 2] == 2'b11)))
      |=> lane_bad[i]);
  end
endmodule

bind tern_prim_unit tern_prim_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/sim_tern_prim_unit.sv
`timescale 1ns/1ps
module sim_tern_prim_unit;
  localparam int L = 4;
  localparam int W = 2 * L;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   op_sel = 3'd0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] result;
  logic [L-1:0] lane_bad;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit bp_on = 1'b0;
  int cyc = 0;

  logic [W-1:0] q_res[$];
  logic [L-1:0] q_bad[$];
  string        q_tag[$];

  always #2 clk = ~clk;

  tern_prim_unit #(.LANES(L)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sel(op_sel), .opa(opa), .opb(opb), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .lane_bad(lane_bad)
  );

  // reference: returns {bad, digit}
  function automatic logic [2:0] ref_lane(int op, logic [1:0] a, logic [1:0] b);
    int va, vb, mn, s, r;
    if (a == 2'b11 || b == 2'b11 || op > 4) return 3'b100;
    va = int'(a); vb = int'(b);
    mn = (va < vb) ? va : vb;
    s = va + vb;
    if (s > 2) s = 2;
    case (op)
      0: r = 2 - va;
      1: r = mn;
      2: r = s;
      3: r = 2 - mn;
      default: r = 2 - s;
    endcase
    return {1'b0, 2'(r)};
  endfunction

  task automatic check(string tag, logic [W+L-1:0] act, logic [W+L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b, string tag);
    logic [W-1:0] er;
    logic [L-1:0] eb;
    for (int i = 0; i < L; i++) begin
      logic [2:0] t;
      t = ref_lane(int'(op), a[2*i +: 2], b[2*i +: 2]);
      er[2*i +: 2] = t[1:0];
      eb[i] = t[2];
    end
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; opa = a; opb = b;
    q_res.push_back(er); q_bad.push_back(eb); q_tag.push_back(tag);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic sweep_ops();
    string tags[5];
    tags = '{"R1", "R2", "R3", "R4", "R5"};
    for (int op = 0; op < 5; op++) begin
      for (int p = 0; p < 9; p++) begin
        logic [W-1:0] a, b;
        for (int i = 0; i < L; i++) begin
          int k;
          k = (p + 2 * i) % 9;
          a[2*i +: 2] = 2'(k / 3);
          b[2*i +: 2] = 2'(k % 3);
        end
        send(3'(op), a, b, tags[op]);
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // consumer back-pressure, changed away from edges
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready = bp_on ? ((cyc % 3) != 0 && (cyc % 7) != 2) : 1'b1;
  end

  // monitor / scoreboard
  logic         was_stall = 1'b0;
  logic [W-1:0] held_res;
  logic [L-1:0] held_bad;
  always @(negedge clk) begin
    if (rst_n) begin
      if (was_stall)  // R8 hold during stall
        check("R8 hold", {out_valid, lane_bad, result}, {1'b1, held_bad, held_res});
      was_stall = out_valid && !out_ready;
      held_res = result;
      held_bad = lane_bad;
      if (out_valid && out_ready) begin
        if (q_res.size() == 0) begin
          check("R8 extra result", {lane_bad, result}, '0);
          errors++;
        end else begin
          logic [W-1:0] er;
          logic [L-1:0] eb;
          string tg;
          er = q_res.pop_front(); eb = q_bad.pop_front(); tg = q_tag.pop_front();
          check(tg, {lane_bad, result}, {eb, er});
        end
      end
    end
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9 reset", {{(W+L-2){1'b0}}, out_valid, in_ready}, {{(W+L-2){1'b0}}, 1'b0, 1'b1});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 idle after reset", {{(W+L-2){1'b0}}, out_valid, in_ready}, {{(W+L-2){1'b0}}, 1'b0, 1'b1});

    sweep_ops();
    // R6: one bad lane among legal ones, per lane position and operand side
    for (int i = 0; i < L; i++) begin
      logic [W-1:0] a, b;
      a = 8'b01_10_00_01; b = 8'b10_01_10_00;
      if (i % 2 == 0) a[2*i +: 2] = 2'b11; else b[2*i +: 2] = 2'b11;
      send(3'(i % 5), a, b, "R6");
    end
    send(3'd1, 8'b11_11_11_11, 8'b00_01_10_11, "R6");
    // R7: unused selects
    send(3'd5, 8'b00_01_10_01, 8'b10_01_00_10, "R7");
    send(3'd6, 8'b01_01_01_01, 8'b10_10_10_10, "R7");
    send(3'd7, 8'b10_00_01_10, 8'b00_00_01_10, "R7");
    // R8: repeat under back-pressure
    bp_on = 1'b1;
    sweep_ops();
    send(3'd5, 8'b00_00_00_00, 8'b00_00_00_00, "R7");
    send(3'd2, 8'b11_00_10_01, 8'b01_11_10_01, "R6");
    bp_on = 1'b0;

    for (int t = 0; t < 50 && q_res.size() != 0; t++) @(negedge clk);
    // R8 nothing lost
    check("R8 drained", {{(W+L-1){1'b0}}, (q_res.size() == 0)}, {{(W+L-1){1'b0}}, 1'b1});
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule